// File: doc/BRIEF.md
# Programmable-Threshold FIFO Flag Unit

This block is a single-clock first-in first-out buffer for 18-bit words. Its depth is a parameter, a power of two from 64 to 4096. It drives five active-low status flags: empty, almost-empty, half-full, almost-full and full. All flags are registered and change on the same clock edge as the access that changes the stored word count.

The almost-empty and almost-full thresholds come from two 12-bit offset registers. No extra bus is needed to reach them. While the load input is low, the data ports carry offset traffic instead of FIFO traffic. A write enable stores `din[11:0]` into one offset register, and a read enable places one offset register on `dout[11:0]`. Each direction steps through the two registers in a fixed alternating order and keeps its own position. That position persists while load is high.

Top module: `thresh_fifo`

## Requirements
- R1: With `load_n` high, a low `wr_en_n` stores `din` when the FIFO is not full. A low `rd_en_n` loads the oldest stored word into the `dout` register on that same edge when the FIFO is not empty. Words leave in arrival order.
- R2: A write is refused while the FIFO holds DEPTH words, whatever the enables say. A read is refused while it holds zero words. `dout` then keeps the last word it showed.
- R3: `empty_n` is low exactly when the count is 0, and `full_n` is low exactly when the count is DEPTH. Both are updated on the edge of the access that changes the count.
- R4: `almost_empty_n` is low when the count is less than or equal to the empty offset n.
- R5: `almost_full_n` is low when the count is greater than or equal to DEPTH minus the full offset m.
- R6: `half_full_n` is low when the count is greater than DEPTH/2.
- R7: When `load_n` and `wr_en_n` are both low, each edge writes `din[11:0]` to the next offset register. The order is empty offset (n), then full offset (m), then n again, and so on.
- R8: Taking `load_n` high between offset writes does not reset the write order. The next offset write goes to the register after the last one written.
- R9: When `load_n` and `rd_en_n` are both low, each edge puts the next offset register on `dout[11:0]` with `dout[17:12]` zero. The order is n, then m, alternating, with a position kept separately from the write order.
- R10: With `load_n` low, a low `wr_en_n` does not write the FIFO, and a low `rd_en_n` does not read it. With `load_n` low and `wr_en_n` high, no offset register changes.
- R11: A synchronous active-high `rst` empties the FIFO and clears `dout`. It loads the default offsets: DEPTH/8-1 capped at 127, which is 7 for a depth of 64. It returns both orders to the empty offset. After reset `empty_n`=0, `almost_empty_n`=0, `half_full_n`=1, `almost_full_n`=1 and `full_n`=1.
- R12: A FIFO read and a FIFO write on the same edge leave the count unchanged when both are allowed. At count 0 only the write takes effect, and at count DEPTH only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| load_n | input | 1 | Offset access select, active low |
| din | input | 18 | Write data, or offset value in bits 11:0 |
| dout | output | 18 | Registered read data, or offset value in bits 11:0 |
| empty_n | output | 1 | Low when no words are stored |
| almost_empty_n | output | 1 | Low when count <= empty offset |
| half_full_n | output | 1 | Low when count > DEPTH/2 |
| almost_full_n | output | 1 | Low when count >= DEPTH - full offset |
| full_n | output | 1 | Low when DEPTH words are stored |

## Verification
Every result of this block is due on the edge that takes the access: `dout` for a FIFO read or an offset read, and all five flags for any change in count or offset. No result has a further cycle of delay. The bench drives inputs on the falling edge. It compares `dout` with the front of its scoreboard queue one time unit after the next rising edge, and compares the flags two units after that edge. A reference count and a reference pair of offsets, updated with the access, give the expected flag values for that same edge.

// File: rtl/thresh_fifo_pkg.sv
package thresh_fifo_pkg;

   // which offset register a load access addresses
   typedef enum logic {
      SEL_EMPTY = 1'b0,
      SEL_FULL  = 1'b1
   } ofs_sel_e;

   // reset threshold: one eighth of the depth minus one, never above 127
   function automatic int default_offset(input int depth);
      int v;
      v = depth / 8 - 1;
      if (v > 127) v = 127;
      return v;
   endfunction

   function automatic ofs_sel_e next_sel(input ofs_sel_e s);
      return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
   endfunction

endpackage

// File: rtl/offset_bank.sv
module offset_bank
   import thresh_fifo_pkg::*;
#(
   parameter int OW      = 12,
   parameter int DEF_AE  = 7,
   parameter int DEF_AF  = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld_wr,
   input  logic          ld_rd,
   input  logic [OW-1:0] wdata,
   output logic [OW-1:0] n_nxt,
   output logic [OW-1:0] m_nxt,
   output logic [OW-1:0] rd_val
);

   ofs_sel_e      wsel_q, rsel_q;
   logic [OW-1:0] ofs_q [2];

   // one register per threshold, each with its own reset default
   for (genvar k = 0; k < 2; k++) begin : g_ofs
      localparam logic [OW-1:0] RST_VAL = (k == 0) ? OW'(DEF_AE) : OW'(DEF_AF);
      always_ff @(posedge clk) begin
         if (rst)
            ofs_q[k] <= RST_VAL;
         else if (ld_wr && (wsel_q == ofs_sel_e'(k)))
            ofs_q[k] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wsel_q <= SEL_EMPTY;
         rsel_q <= SEL_EMPTY;
      end else begin
         if (ld_wr) wsel_q <= next_sel(wsel_q);
         if (ld_rd) rsel_q <= next_sel(rsel_q);
      end
   end

   // values as they stand after this edge, so flags follow a new threshold at once
   assign n_nxt  = (ld_wr && wsel_q == SEL_EMPTY) ? wdata : ofs_q[0];
   assign m_nxt  = (ld_wr && wsel_q == SEL_FULL)  ? wdata : ofs_q[1];
   assign rd_val = (rsel_q == SEL_FULL) ? ofs_q[1] : ofs_q[0];

   // R7: every offset write moves the write order on
   assert_wr_order_R7: assert property (@(posedge clk) disable iff (rst)
      ld_wr |=> wsel_q != $past(wsel_q));

   // R8: a cycle with no offset write keeps the write position
   assert_keep_pos_R8: assert property (@(posedge clk) disable iff (rst)
      !ld_wr |=> $stable(wsel_q));

   // R9: every offset read moves the read order on
   assert_rd_order_R9: assert property (@(posedge clk) disable iff (rst)
      ld_rd |=> rsel_q != $past(rsel_q));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 18,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_word,
   output logic          pop_fire,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic          push_fire;

   // overflow and underflow guards
   assign push_fire = push_req && (cnt_q != CW'(DEPTH));
   assign pop_fire  = pop_req  && (cnt_q != '0);

   always_comb begin
      unique case ({push_fire, pop_fire})
         2'b10:   cnt_nxt = cnt_q + CW'(1);
         2'b01:   cnt_nxt = cnt_q - CW'(1);
         default: cnt_nxt = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (push_fire) mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_fire) wptr_q <= wptr_q + AW'(1);
         if (pop_fire)  rptr_q <= rptr_q + AW'(1);
         cnt_q <= cnt_nxt;
      end
   end

   assign rd_word = mem[rptr_q];

   // R2: a full store refuses a write that has no read beside it
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CW'(DEPTH) && push_req && !pop_req) |=> $stable(wptr_q));

   // R2: an empty store refuses a read
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && pop_req) |=> $stable(rptr_q));

   // R12: the count moves by at most one word per edge
   assert_count_step_R12: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)
                || cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
   parameter int DEPTH = 64,
   parameter int CW    = 7,
   parameter int OW    = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_nxt,
   input  logic [OW-1:0] n_nxt,
   input  logic [OW-1:0] m_nxt,
   output logic          empty_n,
   output logic          almost_empty_n,
   output logic          half_full_n,
   output logic          almost_full_n,
   output logic          full_n
);

   localparam int SW = ((CW > OW) ? CW : OW) + 1;

   logic [SW-1:0] cnt_w, fill_sum;

   assign cnt_w    = SW'(cnt_nxt);
   assign fill_sum = cnt_w + SW'(m_nxt);

   always_ff @(posedge clk) begin
      if (rst) begin
         empty_n        <= 1'b0;
         almost_empty_n <= 1'b0;
         half_full_n    <= 1'b1;
         almost_full_n  <= 1'b1;
         full_n         <= 1'b1;
      end else begin
         empty_n        <= (cnt_nxt != '0);
         almost_empty_n <= !(cnt_w <= SW'(n_nxt));
         half_full_n    <= !(cnt_nxt > CW'(DEPTH / 2));
         almost_full_n  <= !(fill_sum >= SW'(DEPTH));
         full_n         <= (cnt_nxt != CW'(DEPTH));
      end
   end

   // R4: an empty store is always below the almost-empty threshold
   assert_empty_in_ae_R4: assert property (@(posedge clk) disable iff (rst)
      !empty_n |-> !almost_empty_n);

   // R5 and R6: a full store is always almost full and past half
   assert_full_in_af_R5: assert property (@(posedge clk) disable iff (rst)
      !full_n |-> (!almost_full_n && !half_full_n));

endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo
   import thresh_fifo_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int OFS_W  = 12,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              load_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              almost_empty_n,
   output logic              half_full_n,
   output logic              almost_full_n,
   output logic              full_n
);

   localparam int AW     = $clog2(DEPTH);
   localparam int CW     = AW + 1;
   localparam int DEF_OF = default_offset(DEPTH);

   if (DEPTH < 64 || DEPTH > 4096 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("thresh_fifo: DEPTH must be a power of two from 64 to 4096");
   end
   if (DATA_W <= OFS_W) begin : g_bad_width
      $error("thresh_fifo: DATA_W must exceed OFS_W");
   end

   logic              ld_wr, ld_rd, push_req, pop_req, pop_fire;
   logic [DATA_W-1:0] rd_word;
   logic [CW-1:0]     cnt_q, cnt_nxt;
   logic [OFS_W-1:0]  n_nxt, m_nxt, ofs_val;

   // the load select steers both enables between the two targets
   assign ld_wr    = !load_n && !wr_en_n;
   assign ld_rd    = !load_n && !rd_en_n;
   assign push_req =  load_n && !wr_en_n;
   assign pop_req  =  load_n && !rd_en_n;

   fifo_store #(.DEPTH(DEPTH), .DW(DATA_W), .AW(AW), .CW(CW)) u_store (
      .clk      (clk),
      .rst      (rst),
      .push_req (push_req),
      .pop_req  (pop_req),
      .wdata    (din),
      .rd_word  (rd_word),
      .pop_fire (pop_fire),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt)
   );

   offset_bank #(.OW(OFS_W), .DEF_AE(DEF_OF), .DEF_AF(DEF_OF)) u_ofs (
      .clk    (clk),
      .rst    (rst),
      .ld_wr  (ld_wr),
      .ld_rd  (ld_rd),
      .wdata  (din[OFS_W-1:0]),
      .n_nxt  (n_nxt),
      .m_nxt  (m_nxt),
      .rd_val (ofs_val)
   );

   flag_gen #(.DEPTH(DEPTH), .CW(CW), .OW(OFS_W)) u_flags (
      .clk            (clk),
      .rst            (rst),
      .cnt_nxt        (cnt_nxt),
      .n_nxt          (n_nxt),
      .m_nxt          (m_nxt),
      .empty_n        (empty_n),
      .almost_empty_n (almost_empty_n),
      .half_full_n    (half_full_n),
      .almost_full_n  (almost_full_n),
      .full_n         (full_n)
   );

   always_ff @(posedge clk) begin
      if (rst)
         dout <= '0;
      else if (ld_rd)
         dout <= {{(DATA_W-OFS_W){1'b0}}, ofs_val};
      else if (pop_fire)
         dout <= rd_word;
   end

   // R10: offset traffic never changes the stored count
   assert_load_no_fifo_R10: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> $stable(cnt_q));

   // R2: a read on an empty store leaves dout as it was
   assert_hold_empty_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && load_n) |=> $stable(dout));

   // R3: empty and full are never both asserted
   assert_flag_excl_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({~empty_n, ~full_n}));

endmodule

// File: tb/thresh_fifo_test.sv
module thresh_fifo_test;

   localparam int CLK_PERIOD = 10;
   localparam int D          = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1;
   logic [17:0] din = '0;
   logic [17:0] dout;
   logic        empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

   thresh_fifo #(.DATA_W(18), .OFS_W(12), .DEPTH(D)) uut (
      .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n),
      .din(din), .dout(dout), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
      .half_full_n(half_full_n), .almost_full_n(almost_full_n), .full_n(full_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          total = 0, bad = 0;
   logic [17:0] sb_q[$];
   logic [17:0] fq[$];
   int          m_cnt;
   logic [11:0] m_n, m_m;
   bit          m_wsel, m_rsel;
   logic [17:0] m_dout;
   string       mon_req = "R1";

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: pops the expected read result once the design has produced it
   always @(posedge clk) begin
      logic [17:0] e;
      #1;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk(dout == e, mon_req, "dout", int'(dout), int'(e));
      end
   end

   task automatic check_flags(input string req);
      logic [4:0] exp, act;
      exp = {m_cnt != 0, !(m_cnt <= int'(m_n)), !(m_cnt > D/2),
             !(m_cnt + int'(m_m) >= D), m_cnt != D};
      act = {empty_n, almost_empty_n, half_full_n, almost_full_n, full_n};
      chk(act == exp, req, "flags{e,ae,hf,af,f}", int'(act), int'(exp));
   endtask

   // driver: applies one cycle, pushes the expected dout, advances the reference
   task automatic step(input bit wr, input bit rd, input bit ld,
                       input logic [17:0] d, input string req);
      bit          l_wr, l_rd, f_wr, f_rd;
      logic [17:0] exp;
      @(negedge clk);
      wr_en_n = wr; rd_en_n = rd; load_n = ld; din = d;
      mon_req = req;
      l_wr = !ld && !wr;
      l_rd = !ld && !rd;
      f_wr = ld && !wr && (m_cnt < D);
      f_rd = ld && !rd && (m_cnt > 0);
      if (!rd) begin
         if (l_rd)      exp = {6'b0, (m_rsel ? m_m : m_n)};
         else if (f_rd) exp = fq[0];
         else           exp = m_dout;
         sb_q.push_back(exp);
         m_dout = exp;
      end
      if (l_rd) m_rsel = !m_rsel;
      if (l_wr) begin
         if (!m_wsel) m_n = d[11:0]; else m_m = d[11:0];
         m_wsel = !m_wsel;
      end
      if (f_rd) begin void'(fq.pop_front()); m_cnt--; end
      if (f_wr) begin fq.push_back(d); m_cnt++; end
      @(posedge clk);
      #2;
      check_flags(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; load_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      sb_q.delete(); fq.delete();
      m_cnt = 0; m_n = 12'd7; m_m = 12'd7; m_wsel = 0; m_rsel = 0; m_dout = '0;
      // R11: state straight after reset
      chk(dout == 18'd0, "R11", "dout after reset", int'(dout), 0);
      check_flags("R11");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      do_reset();
      // R11: defaults read back as 7 then 7
      step(1, 0, 0, 0, "R11");
      step(1, 0, 0, 0, "R11");
      // R7 and R8: write n, pause with load high, write m
      step(0, 1, 0, 18'd3, "R7");
      step(1, 1, 1, 0, "R8");
      step(0, 1, 0, 18'd5, "R8");
      // R9: read back n then m
      step(1, 0, 0, 0, "R9");
      step(1, 0, 0, 0, "R9");
      // R10: load low with enables high changes nothing
      step(1, 1, 0, 18'd999, "R10");
      step(1, 0, 0, 0, "R10");
      step(1, 0, 0, 0, "R10");
      // R10: load low with write enable does not push into the FIFO
      step(0, 1, 0, 18'd2, "R7");
      step(1, 0, 0, 0, "R9");
      step(1, 0, 0, 0, "R9");
      // R1, R4, R5, R6, R3: fill to DEPTH, flags checked every cycle
      for (int i = 0; i < D; i++) step(0, 1, 1, 18'(i * 1031 + 7), "R1 R3 R4 R5 R6");
      // R2: write while full refused
      step(0, 1, 1, 18'h3ffff, "R2");
      // R12: read and write at full, read only
      step(0, 0, 1, 18'h155, "R12");
      // R1: drain in order
      while (m_cnt > 0) step(1, 0, 1, 0, "R1");
      // R2: read while empty holds dout
      step(1, 0, 1, 0, "R2");
      step(1, 0, 1, 0, "R2");
      // R12: read and write at empty, write only; then paired traffic
      step(0, 0, 1, 18'h222, "R12");
      for (int i = 0; i < 10; i++) step(0, 0, 1, 18'(500 + i), "R12");
      // R1: mixed random traffic
      for (int i = 0; i < 400; i++)
         step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 1'b1,
              18'($urandom), "R1");
      // R11: reset mid-run restores defaults and both orders
      do_reset();
      step(1, 0, 0, 0, "R11");
      step(1, 0, 0, 0, "R11");
      step(0, 1, 0, 18'd4, "R11");
      step(1, 0, 0, 0, "R11");
      step(1, 0, 0, 0, "R11");
      step(1, 1, 1, 0, "R11");
      summary();
      $finish;
   end

endmodule